// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block passes an 18-bit word between an A side and a B side, with one storage cell for each direction. Each direction has three controls: a latch-enable, a storage clock and an output-enable. The latch-enable and the storage clock choose how the cell behaves. With the latch-enable high, the cell is transparent. With it low, the cell holds its value, or it loads on a falling edge of the storage clock. The output-enable decides whether the far port drives what the cell holds.

The latch-enable and storage-clock inputs are slow controls. The block samples them on a faster system clock. A falling edge is seen when the previous sample of the storage clock was 1 and the current sample is 0. A transparent cell reloads on every system clock.

Each port is split into three signals: incoming data, a flag saying whether the far side drives that data, and outgoing data with its own drive-enable. When the far side stops driving, a bus-hold register keeps the last driven word. The storage path therefore never sees an undriven value. A contention flag is raised when both output-enables are active together.

Top module: `bidir_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage cells, both bus-hold registers and both sampled storage clocks are zero. With an output-enable high, the matching output port reads 0.
- R2: With `ab_le` high, `b_out` equals the value `a_in` had at the previous system clock edge. In other words, the cell reloads on every system clock.
- R3: With `ab_le` low, the A-to-B cell keeps its value when the sampled `ab_clk` stays low for consecutive samples, and also when it stays high for consecutive samples.
- R4: With `ab_le` low, a sample of `ab_clk` equal to 0 that follows a sample equal to 1 loads the current A input. The new value appears on `b_out` after that system clock edge.
- R5: With `ab_le` low, a sample of `ab_clk` equal to 1 that follows a sample equal to 0 (a rising edge) leaves the cell unchanged.
- R6: `b_oe` equals `ab_oe` and `a_oe` equals `ba_oe`, combinationally. While a drive-enable is low, the data on that port reads all zeros.
- R7: The B-to-A direction obeys R2 to R5 with `ba_le`, `ba_clk`, `b_in` and `a_out`.
- R8: While a port's drive flag (`a_drv` or `b_drv`) is low, the cell behind that port sees the last word that was present while the flag was high. The word now on the input pins is ignored.
- R9: `contention` is 1 exactly when `ab_oe` and `ba_oe` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all controls |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in | input | 18 | Data arriving on the A side |
| a_drv | input | 1 | High while the far side drives `a_in` |
| a_out | output | 18 | Data the block drives onto the A side |
| a_oe | output | 1 | High while the block drives the A side |
| b_in | input | 18 | Data arriving on the B side |
| b_drv | input | 1 | High while the far side drives `b_in` |
| b_out | output | 18 | Data the block drives onto the B side |
| b_oe | output | 1 | High while the block drives the B side |
| ab_le | input | 1 | A-to-B latch-enable, transparent when high |
| ab_clk | input | 1 | A-to-B storage clock, loads on its falling edge |
| ab_oe | input | 1 | B-side output-enable, active high |
| ba_le | input | 1 | B-to-A latch-enable, transparent when high |
| ba_clk | input | 1 | B-to-A storage clock, loads on its falling edge |
| ba_oe | input | 1 | A-side output-enable, active high |
| contention | output | 1 | High while both output-enables are active |

## Verification
Some rules are checked by assertions on every system clock:
- a transparent cell reloads from its input;
- a cell with no falling edge keeps its value;
- a detected falling edge loads the input;
- an undriven input shows the held word;
- a disabled port reads zero.

Other behaviour can only be shown by the directed scenarios, because it depends on sequences of control levels:
- the full input-to-output path in both directions;
- the difference between rising and falling storage-clock edges;
- holding with the storage clock high and with it low;
- bus-hold retention seen at the far port.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;

  typedef enum logic [1:0] {
    CELL_PASS = 2'd0,
    CELL_KEEP = 2'd1,
    CELL_LOAD = 2'd2
  } cell_mode_t;
endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv,
  input  logic [W-1:0] pin,
  output logic [W-1:0] val
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (drv) held_d = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign val = drv ? pin : held_q;

  assert_hold_shown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv |-> (val == held_q));
  assert_hold_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drv |=> (held_q == $past(pin)));
endmodule

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         sclk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         sclk_q;
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         fall;
  cell_mode_t   mode;

  assign fall = sclk_q & ~sclk;

  always_comb begin
    if (le)        mode = CELL_PASS;
    else if (fall) mode = CELL_LOAD;
    else           mode = CELL_KEEP;
  end

  always_comb begin
    unique case (mode)
      CELL_PASS, CELL_LOAD: q_d = d;
      default:              q_d = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      q_r    <= '0;
    end else begin
      sclk_q <= sclk;
      q_r    <= q_d;
    end
  end

  assign q = q_r;

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (q == $past(d)));
  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !(sclk_q && !sclk)) |=> (q == $past(q)));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && sclk_q && !sclk) |=> (q == $past(d)));
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_drv,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe,
  output logic         contention
);
  localparam int unsigned NDIR = 2;

  // index 0: A to B, index 1: B to A
  logic [NDIR-1:0][W-1:0] src_pin, src_val, cell_q, dst_data;
  logic [NDIR-1:0]        src_drv, le_v, sclk_v, oe_v;

  assign src_pin = {b_in, a_in};
  assign src_drv = {b_drv, a_drv};
  assign le_v    = {ba_le, ab_le};
  assign sclk_v  = {ba_clk, ab_clk};
  assign oe_v    = {ba_oe, ab_oe};

  for (genvar i = 0; i < NDIR; i++) begin : g_dir
    xcvr_bus_hold #(.W(W)) u_hold (
      .clk(clk), .rst_n(rst_n), .drv(src_drv[i]),
      .pin(src_pin[i]), .val(src_val[i])
    );
    xcvr_store_cell #(.W(W)) u_cell (
      .clk(clk), .rst_n(rst_n), .le(le_v[i]), .sclk(sclk_v[i]),
      .d(src_val[i]), .q(cell_q[i])
    );
    assign dst_data[i] = oe_v[i] ? cell_q[i] : '0;
  end

  assign b_out      = dst_data[0];
  assign b_oe       = oe_v[0];
  assign a_out      = dst_data[1];
  assign a_oe       = oe_v[1];
  assign contention = &oe_v;

  assert_quiet_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (b_out == '0));
  assert_quiet_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> (a_out == '0));
  assert_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    contention |-> (a_oe && b_oe));
endmodule

// File: tb/sim_bidir_xcvr.sv
module sim_bidir_xcvr;
  localparam int W = 18;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_drv, b_drv, a_oe, b_oe, contention;
  logic ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe;
  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  bidir_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe(ba_oe),
    .contention(contention)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    a_in = 18'h2AAAA; b_in = 18'h15555; a_drv = 1'b1; b_drv = 1'b1;
    ab_le = 1'b0; ab_clk = 1'b0; ab_oe = 1'b1;
    ba_le = 1'b0; ba_clk = 1'b0; ba_oe = 1'b1;
    step(); step();
    chk("R1 b_out in reset", b_out, '0);
    chk("R1 a_out in reset", a_out, '0);
    chk("R9 contention both enabled", {17'd0, contention}, 18'd1);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 b_out after release", b_out, '0);
  endtask

  task automatic t_pass();
    ab_le = 1'b1; a_in = 18'h12345;
    step();
    chk("R2 transparent first", b_out, 18'h12345);
    a_in = 18'h0F0F0;
    step();
    chk("R2 transparent follow", b_out, 18'h0F0F0);
  endtask

  task automatic t_keep_and_rise();
    ab_le = 1'b0; ab_clk = 1'b0; a_in = 18'h3FFFF;
    step(); step();
    chk("R3 hold clock low", b_out, 18'h0F0F0);
    ab_clk = 1'b1;
    step();
    chk("R5 no load on rising edge", b_out, 18'h0F0F0);
    a_in = 18'h00001;
    step(); step();
    chk("R3 hold clock high", b_out, 18'h0F0F0);
  endtask

  task automatic t_fall();
    a_in = 18'h2B3C4; ab_clk = 1'b0;
    step();
    chk("R4 load on falling edge", b_out, 18'h2B3C4);
    a_in = 18'h11111;
    step();
    chk("R3 hold after load", b_out, 18'h2B3C4);
  endtask

  task automatic t_oe();
    ab_oe = 1'b0;
    #1;
    chk("R6 b_oe off", {17'd0, b_oe}, 18'd0);
    chk("R6 b_out zero when off", b_out, '0);
    chk("R9 contention off", {17'd0, contention}, 18'd0);
    ba_oe = 1'b0;
    #1;
    chk("R6 a_oe off", {17'd0, a_oe}, 18'd0);
    ab_oe = 1'b1; ba_oe = 1'b1;
    #1;
    chk("R6 b_out restored", b_out, 18'h2B3C4);
  endtask

  task automatic t_ba();
    ba_le = 1'b1; b_in = 18'h0ABCD;
    step();
    chk("R7 transparent B to A", a_out, 18'h0ABCD);
    ba_le = 1'b0; ba_clk = 1'b1; b_in = 18'h33333;
    step();
    chk("R7 rising no load", a_out, 18'h0ABCD);
    ba_clk = 1'b0;
    step();
    chk("R7 falling load", a_out, 18'h33333);
    b_in = 18'h00777;
    step();
    chk("R7 hold clock low", a_out, 18'h33333);
  endtask

  task automatic t_bushold();
    ab_le = 1'b1; a_drv = 1'b1; a_in = 18'h1C0DE;
    step();
    a_drv = 1'b0; a_in = 18'h0BEEF;
    step(); step();
    chk("R8 A bus-hold", b_out, 18'h1C0DE);
    ba_le = 1'b1; b_drv = 1'b1; b_in = 18'h2F00D;
    step();
    b_drv = 1'b0; b_in = 18'h3FFFF;
    step(); step();
    chk("R8 B bus-hold", a_out, 18'h2F00D);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_keep_and_rise();
    t_fall();
    t_oe();
    t_ba();
    t_bushold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule